// File: doc/BRIEF.md
# Viterbi Add-Compare-Select Maximum with Decision History

This block does the compare-select step of a Viterbi decoder. Each source word holds two signed path metrics, one per half. For each source word the block picks the larger metric. The two winners are packed into one result word. The block also records which element of each pair won, as a two-bit decision code.

The decision code is shifted into a wide history accumulator. The accumulator has a run of guard bits above the data width. The shift direction is chosen per operation. In left mode the code enters at the bottom. In right mode the code enters just below the guard bits. In both modes the guard bits are cleared on every update.

An enable qualifies each operation. A separate clear input presets the accumulator to zero. The history can then be read out later for traceback.

Top module: `vit_cmp_sel`

## Requirements
- R1: One clock edge after an enabled operation, the upper half of `maxOut` is the signed maximum of the upper and lower halves of `srcB`.
- R2: One clock edge after an enabled operation, the lower half of `maxOut` is the signed maximum of the upper and lower halves of `srcA`.
- R3: The decision code is two bits. Bit 1 is 1 when the upper half of `srcB` wins, and bit 0 is 1 when the upper half of `srcA` wins. When the two halves are equal, the upper half counts as the winner and its bit is set.
- R4: With `shiftRight` low, an enabled operation shifts the accumulator left by two places, and the decision code enters bits 1:0.
- R5: With `shiftRight` high, an enabled operation shifts the accumulator right by two places, and the decision code enters bits 31:30.
- R6: The accumulator's 8 guard bits (39:32) are zero after every update, in both modes.
- R7: While `enable` is low and `clearAcc` is low, both `maxOut` and `histAcc` hold their values.
- R8: `clearAcc` zeroes the accumulator on the next edge, taking priority over an enabled shift. `maxOut` still updates if `enable` is high.
- R9: After reset, `maxOut` and `histAcc` are zero.
- R10: Take `srcA`=0xFFFF0000, `srcB`=0x0000FFFF, left mode and an accumulator of zero. The result is then `maxOut`=0x00000000 and `histAcc`=0x0000000002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| srcA | input | 32 | Source 0: two signed 16-bit metrics |
| srcB | input | 32 | Source 1: two signed 16-bit metrics |
| shiftRight | input | 1 | 1 selects right-shift history mode, 0 selects left |
| enable | input | 1 | Performs an operation this cycle |
| clearAcc | input | 1 | Zeroes the history accumulator |
| maxOut | output | 32 | Packed maxima, source 1 winner in the upper half |
| histAcc | output | 40 | Decision history accumulator |

## Verification
The bench builds the block with its default parameters: 16-bit metrics and 8 guard bits. At these widths, a run of more than sixteen left shifts carries decision bits up to the guard boundary, where they must be discarded. The same widths let right-shift runs fill bit 31 and be checked against a model. Ties, metrics that differ only in sign, and clear arriving alongside enable are all driven, with random patterns mixed between the two modes.

// File: rtl/vcs_pkg.sv
package vcs_pkg;
  typedef struct packed {
    logic loadRes;
    logic shiftAcc;
    logic zeroAcc;
    logic dirRight;
  } vcs_strobe_t;
endpackage

// File: rtl/vcs_pair_max.sv
module vcs_pair_max #(
  parameter int HALF_W = 16
) (
  input  logic [HALF_W-1:0] hiIn,
  input  logic [HALF_W-1:0] loIn,
  output logic [HALF_W-1:0] maxVal,
  output logic              hiWins
);
  // Tie goes to the upper element.
  always_comb begin
    hiWins = $signed(hiIn) >= $signed(loIn);
    maxVal = hiWins ? hiIn : loIn;
  end
endmodule

// File: rtl/vcs_ctrl.sv
module vcs_ctrl
  import vcs_pkg::*;
(
  input  logic        enable,
  input  logic        clearAcc,
  input  logic        shiftRight,
  output vcs_strobe_t strobe
);
  always_comb begin
    strobe.loadRes  = enable;
    strobe.zeroAcc  = clearAcc;
    strobe.shiftAcc = enable & ~clearAcc;
    strobe.dirRight = shiftRight;
  end
endmodule

// File: rtl/vcs_datapath.sv
module vcs_datapath
  import vcs_pkg::*;
#(
  parameter int HALF_W  = 16,
  parameter int GUARD_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [2*HALF_W-1:0]           srcA,
  input  logic [2*HALF_W-1:0]           srcB,
  input  vcs_strobe_t                   strobe,
  output logic [2*HALF_W-1:0]           maxOut,
  output logic [2*HALF_W+GUARD_W-1:0]   histAcc
);
  localparam int LANE_W = 2 * HALF_W;
  localparam int ACC_W  = LANE_W + GUARD_W;

  logic [1:0][LANE_W-1:0] srcPair;
  logic [1:0][HALF_W-1:0] laneMax;
  logic [1:0]             decBits;
  logic [LANE_W-1:0]      resReg;
  logic [ACC_W-1:0]       accReg;
  logic [ACC_W-1:0]       accNext;

  assign srcPair[0] = srcA;
  assign srcPair[1] = srcB;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    vcs_pair_max #(.HALF_W(HALF_W)) i_pair (
      .hiIn  (srcPair[g][LANE_W-1:HALF_W]),
      .loIn  (srcPair[g][HALF_W-1:0]),
      .maxVal(laneMax[g]),
      .hiWins(decBits[g])
    );
  end

  always_comb begin
    if (strobe.dirRight)
      accNext = {{GUARD_W{1'b0}}, decBits, accReg[LANE_W-1:2]};
    else
      accNext = {{GUARD_W{1'b0}}, accReg[LANE_W-3:0], decBits};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resReg <= '0;
      accReg <= '0;
    end else begin
      if (strobe.loadRes) resReg <= {laneMax[1], laneMax[0]};
      if (strobe.zeroAcc) accReg <= '0;
      else if (strobe.shiftAcc) accReg <= accNext;
    end
  end

  assign maxOut  = resReg;
  assign histAcc = accReg;

  a_r1_hi_max: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadRes |=> ($signed(maxOut[LANE_W-1:HALF_W]) >= $signed($past(srcB[LANE_W-1:HALF_W])))
                    && ($signed(maxOut[LANE_W-1:HALF_W]) >= $signed($past(srcB[HALF_W-1:0]))));
  a_r2_lo_max: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadRes |=> ($signed(maxOut[HALF_W-1:0]) >= $signed($past(srcA[LANE_W-1:HALF_W])))
                    && ($signed(maxOut[HALF_W-1:0]) >= $signed($past(srcA[HALF_W-1:0]))));
  a_r4_left_shift: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shiftAcc && !strobe.dirRight) |=> histAcc[LANE_W-1:2] == $past(histAcc[LANE_W-3:0]));
  a_r5_right_shift: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shiftAcc && strobe.dirRight) |=> histAcc[LANE_W-3:0] == $past(histAcc[LANE_W-1:2]));
  a_r6_guard_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftAcc |=> histAcc[ACC_W-1:LANE_W] == '0);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadRes && !strobe.zeroAcc) |=> ($stable(histAcc) && $stable(maxOut)));
  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.zeroAcc |=> histAcc == '0);
endmodule

// File: rtl/vit_cmp_sel.sv
module vit_cmp_sel
  import vcs_pkg::*;
#(
  parameter int HALF_W  = 16,
  parameter int GUARD_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [2*HALF_W-1:0]         srcA,
  input  logic [2*HALF_W-1:0]         srcB,
  input  logic                        shiftRight,
  input  logic                        enable,
  input  logic                        clearAcc,
  output logic [2*HALF_W-1:0]         maxOut,
  output logic [2*HALF_W+GUARD_W-1:0] histAcc
);
  vcs_strobe_t strobe;

  vcs_ctrl i_ctrl (
    .enable    (enable),
    .clearAcc  (clearAcc),
    .shiftRight(shiftRight),
    .strobe    (strobe)
  );

  vcs_datapath #(.HALF_W(HALF_W), .GUARD_W(GUARD_W)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .srcA   (srcA),
    .srcB   (srcB),
    .strobe (strobe),
    .maxOut (maxOut),
    .histAcc(histAcc)
  );
endmodule

// File: tb/test_vit_cmp_sel.sv
module test_vit_cmp_sel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcA = '0;
  logic [31:0] srcB = '0;
  logic        shiftRight = 1'b0;
  logic        enable = 1'b0;
  logic        clearAcc = 1'b0;
  logic [31:0] maxOut;
  logic [39:0] histAcc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] expRes;
    logic [39:0] expAcc;
    string       tag;
  } item_t;
  item_t sbQ[$];

  logic [31:0] mdlRes = '0;
  logic [39:0] mdlAcc = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vit_cmp_sel i_vit_cmp_sel (
    .clk(clk), .rstN(rstN), .srcA(srcA), .srcB(srcB),
    .shiftRight(shiftRight), .enable(enable), .clearAcc(clearAcc),
    .maxOut(maxOut), .histAcc(histAcc)
  );

  function automatic logic [15:0] smax(input logic [15:0] a, input logic [15:0] b);
    return ($signed(a) >= $signed(b)) ? a : b;
  endfunction

  task automatic check(input string tag, input logic [31:0] r, input logic [39:0] a);
    checks++;
    if (maxOut !== r || histAcc !== a) begin
      failures++;
      $display("FAIL %s: maxOut=%h histAcc=%h expected maxOut=%h histAcc=%h",
               tag, maxOut, histAcc, r, a);
    end
  endtask

  // Driver: drive one cycle of stimulus and push the modelled outcome.
  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic dir,
                       input logic en, input logic clr, input string tag);
    logic [1:0] bb;
    item_t it;
    srcA = a; srcB = b; shiftRight = dir; enable = en; clearAcc = clr;
    bb[1] = $signed(b[31:16]) >= $signed(b[15:0]);
    bb[0] = $signed(a[31:16]) >= $signed(a[15:0]);
    if (en) mdlRes = {smax(b[31:16], b[15:0]), smax(a[31:16], a[15:0])};
    if (clr) mdlAcc = '0;
    else if (en) begin
      if (dir) mdlAcc = {8'h00, bb, mdlAcc[31:2]};
      else     mdlAcc = {8'h00, mdlAcc[29:0], bb};
    end
    it.expRes = mdlRes; it.expAcc = mdlAcc; it.tag = tag;
    sbQ.push_back(it);
    @(negedge clk);
  endtask

  // Monitor: compare just after each rising edge.
  always @(posedge clk) begin
    #1;
    if (sbQ.size() > 0) begin
      item_t it;
      it = sbQ.pop_front();
      check(it.tag, it.expRes, it.expAcc);
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset", 32'h0, 40'h0);
    rstN = 1'b1;
    @(negedge clk);
    // R10 worked example, also R1 R2 R3 R4
    drive(32'hFFFF0000, 32'h0000FFFF, 1'b0, 1'b1, 1'b0, "R10 example");
    // R3 ties: equal halves pick upper, bits set
    drive(32'h12341234, 32'h80008000, 1'b0, 1'b1, 1'b0, "R3 tie");
    // R1 R2 sign-sensitive patterns
    drive(32'h7FFF8000, 32'h80007FFF, 1'b0, 1'b1, 1'b0, "R1 R2 extremes");
    drive(32'hFFFEFFFF, 32'h00010000, 1'b0, 1'b1, 1'b0, "R1 R2 negatives");
    // R7 hold with enable low
    drive(32'h11112222, 32'h33334444, 1'b1, 1'b0, 1'b0, "R7 hold");
    drive(32'h55556666, 32'h77778888, 1'b0, 1'b0, 1'b0, "R7 hold2");
    // R4 R6 long left run overflowing into guard region
    for (int i = 0; i < 20; i++)
      drive(32'h00010000, 32'h00050001, 1'b0, 1'b1, 1'b0, "R4 R6 left run");
    // R8 clear with enable active
    drive(32'h00020001, 32'h00030004, 1'b0, 1'b1, 1'b1, "R8 clear priority");
    // R5 right run filling bit 31
    for (int i = 0; i < 18; i++)
      drive(32'h00050001 + i, 32'h00010007 - i, 1'b1, 1'b1, 1'b0, "R5 right run");
    drive(32'h0, 32'h0, 1'b1, 1'b0, 1'b1, "R8 clear no enable");
    // Mixed random patterns, both modes
    for (int i = 0; i < 60; i++)
      drive($urandom, $urandom, 1'($urandom), 1'($urandom_range(0, 3) != 0),
            1'($urandom_range(0, 15) == 0), "R1 R2 R4 R5 R6 mixed");
    drive(32'h0, 32'h0, 1'b0, 1'b0, 1'b0, "R7 final hold");
    enable = 1'b0; clearAcc = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule